// File: doc/BRIEF.md
# Trap Entry Controller

This block does the architectural bookkeeping of taking a trap in a hart that has machine, supervisor and user privilege. A trap request arrives with a cause code, an interrupt flag, the faulting address and the PC of the trapping instruction. In the same cycle the block picks the target privilege and presents the redirect PC. At the following clock edge it commits the status-bit stack, the cause, exception-PC and trap-value registers of the chosen level, and the new privilege.

The block owns the exception and interrupt delegation masks, both trap-vector registers, the six status fields and the current privilege. All of them are loaded through a plain configuration write port. The trap request is a valid-only stream with no back-pressure: the block is always ready, so every cycle with `trap_valid` high is a trap taken in that cycle. A configuration write in the same cycle as a trap is dropped.

Privilege encoding is U = 0, S = 1, M = 3. A configuration write of the reserved value 2 to the privilege stores U. Configuration select codes are: 0 exception delegation, 1 interrupt delegation, 2 machine vector, 3 supervisor vector, 4 status, 5 privilege. The status word packs SIE at bit 0, MIE at bit 1, SPIE at bit 2, MPIE at bit 3, SPP at bit 4 and MPP at bits 6:5.

Top module: `trap_entry_ctrl`

## Requirements
- R1: Delegation goes to S only when the current privilege is U or S, the effective cause code is below XLEN, and that code's bit is set in the matching mask. The interrupt mask is used for interrupts and the exception mask for exceptions. Every other trap goes to M.
- R2: A trap taken while in M always goes to M, whatever the masks hold.
- R3: On entry to S, SPIE takes the old SIE, SPP takes 1 if the old privilege was S and 0 if it was U, and SIE clears. The M fields stay unchanged.
- R4: On entry to M, MPIE takes the old MIE, MPP takes the old privilege and MIE clears. The S fields stay unchanged.
- R5: The target level's cause register gets the effective code in its low bits and bit XLEN-1 set for interrupts. Its EPC register gets `pc_in`.
- R6: When a trap is taken, `trap_pc` is the target level's vector register with bits 1:0 cleared. This applies to every exception, and to interrupts whose vector mode field (bits 1:0) is not 1.
- R7: For an interrupt with vector mode field 1, `trap_pc` is that cleared base plus 4 times the cause code.
- R8: For exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15, the target level's trap-value register gets `trap_addr`. For every other exception and for all interrupts it gets zero.
- R9: An exception with code 8 is rewritten by the current privilege to 8 (U), 9 (S) or 11 (M). The rewritten code is used for delegation, vectoring and the cause register.
- R10: `trap_taken` and `trap_to_s` are valid in the cycle `trap_valid` is high. After the edge, `cur_priv` is S or M to match the target.
- R11: A cause code of XLEN or more never delegates, even with every mask bit set.
- R12: After reset the privilege is M and every status bit, mask, vector and trap register is zero.
- R13: A configuration write takes effect at the next edge when no trap is present. In a cycle with a trap, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request, always accepted |
| trap_irq | input | 1 | 1 for interrupt, 0 for exception |
| trap_code | input | CAUSE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| pc_in | input | XLEN | PC of the trapping instruction |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | XLEN | Configuration write data |
| trap_taken | output | 1 | Trap accepted this cycle |
| trap_to_s | output | 1 | Trap targets supervisor |
| trap_pc | output | XLEN | Redirect PC |
| cur_priv | output | 2 | Current privilege |
| st_sie | output | 1 | Supervisor interrupt enable |
| st_mie | output | 1 | Machine interrupt enable |
| st_spie | output | 1 | Supervisor prior enable |
| st_mpie | output | 1 | Machine prior enable |
| st_spp | output | 1 | Supervisor prior privilege |
| st_mpp | output | 2 | Machine prior privilege |
| m_cause | output | XLEN | Machine cause |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine trap value |
| s_cause | output | XLEN | Supervisor cause |
| s_epc | output | XLEN | Supervisor exception PC |
| s_tval | output | XLEN | Supervisor trap value |

## Verification
Delegation is tried from U, S and M. The test sets one mask bit at a time and sends the same code once as an exception and once as an interrupt, which shows that the two masks are kept apart and that M never delegates. Environment calls are sent from each privilege against a mask that delegates only code 8, which shows that the rewrite happens before the delegation lookup. Address-bearing causes are compared against breakpoint causes and interrupts to separate a trap value of `trap_addr` from one of zero. Vector mode 1 is applied to both interrupts and exceptions, and the out-of-range code 40 is sent with all-ones masks. A configuration write is issued together with a trap to show that the trap takes priority.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [2:0] {
    CFG_EDELEG = 3'd0,
    CFG_IDELEG = 3'd1,
    CFG_MVEC   = 3'd2,
    CFG_SVEC   = 3'd3,
    CFG_STATUS = 3'd4,
    CFG_PRIV   = 3'd5
  } cfg_sel_e;

  localparam int ECALL_BASE = 8;

  // exception codes that carry an address into the trap value register
  function automatic logic carries_addr(input int code);
    case (code)
      0, 1, 4, 5, 6, 7, 12, 13, 15: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] code_i,
  input  logic [1:0]         priv_i,
  input  logic [XLEN-1:0]    edeleg_i,
  input  logic [XLEN-1:0]    ideleg_i,
  output logic [CAUSE_W-1:0] code_o,
  output logic               to_s_o,
  output logic               tval_en_o
);
  localparam int IDX_W = $clog2(XLEN);

  logic [XLEN-1:0] mask;
  logic            in_range;

  always_comb begin
    code_o = code_i;
    if (!irq_i && int'(code_i) == ECALL_BASE) begin
      unique case (priv_i)
        PRIV_S:  code_o = CAUSE_W'(ECALL_BASE + 1);
        PRIV_M:  code_o = CAUSE_W'(ECALL_BASE + 3);
        default: code_o = CAUSE_W'(ECALL_BASE);
      endcase
    end
  end

  assign mask      = irq_i ? ideleg_i : edeleg_i;
  assign in_range  = int'(code_o) < XLEN;
  assign to_s_o    = (priv_i != PRIV_M) && in_range && mask[code_o[IDX_W-1:0]];
  assign tval_en_o = !irq_i && carries_addr(int'(code_o));
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic [XLEN-1:0]    tvec_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] code_i,
  output logic [XLEN-1:0]    pc_o
);
  localparam logic [1:0] MODE_VECTORED = 2'd1;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base   = {tvec_i[XLEN-1:2], 2'b00};
  assign offset = {{(XLEN-CAUSE_W-2){1'b0}}, code_i, 2'b00};
  assign pc_o   = (irq_i && tvec_i[1:0] == MODE_VECTORED) ? base + offset : base;
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_valid,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_code,
  input  logic [XLEN-1:0]    trap_addr,
  input  logic [XLEN-1:0]    pc_in,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [XLEN-1:0]    cfg_wdata,
  output logic               trap_taken,
  output logic               trap_to_s,
  output logic [XLEN-1:0]    trap_pc,
  output logic [1:0]         cur_priv,
  output logic               st_sie,
  output logic               st_mie,
  output logic               st_spie,
  output logic               st_mpie,
  output logic               st_spp,
  output logic [1:0]         st_mpp,
  output logic [XLEN-1:0]    m_cause,
  output logic [XLEN-1:0]    m_epc,
  output logic [XLEN-1:0]    m_tval,
  output logic [XLEN-1:0]    s_cause,
  output logic [XLEN-1:0]    s_epc,
  output logic [XLEN-1:0]    s_tval
);
  logic [XLEN-1:0]    edeleg_q, ideleg_q, mvec_q, svec_q;
  logic [CAUSE_W-1:0] eff_code;
  logic               to_s, tval_en;
  logic [XLEN-1:0]    cause_val, tval_val;

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .irq_i    (trap_irq),
    .code_i   (trap_code),
    .priv_i   (cur_priv),
    .edeleg_i (edeleg_q),
    .ideleg_i (ideleg_q),
    .code_o   (eff_code),
    .to_s_o   (to_s),
    .tval_en_o(tval_en)
  );

  trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .tvec_i(to_s ? svec_q : mvec_q),
    .irq_i (trap_irq),
    .code_i(eff_code),
    .pc_o  (trap_pc)
  );

  assign trap_taken = trap_valid && !rst;
  assign trap_to_s  = to_s;
  assign cause_val  = {trap_irq, {(XLEN-1-CAUSE_W){1'b0}}, eff_code};
  assign tval_val   = tval_en ? trap_addr : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_priv <= PRIV_M;
      {st_sie, st_mie, st_spie, st_mpie, st_spp} <= '0;
      st_mpp   <= PRIV_U;
      edeleg_q <= '0;
      ideleg_q <= '0;
      mvec_q   <= '0;
      svec_q   <= '0;
      m_cause  <= '0;
      m_epc    <= '0;
      m_tval   <= '0;
      s_cause  <= '0;
      s_epc    <= '0;
      s_tval   <= '0;
    end else if (trap_valid) begin
      if (to_s) begin
        st_spie  <= st_sie;
        st_spp   <= (cur_priv == PRIV_S);
        st_sie   <= 1'b0;
        s_cause  <= cause_val;
        s_epc    <= pc_in;
        s_tval   <= tval_val;
        cur_priv <= PRIV_S;
      end else begin
        st_mpie  <= st_mie;
        st_mpp   <= cur_priv;
        st_mie   <= 1'b0;
        m_cause  <= cause_val;
        m_epc    <= pc_in;
        m_tval   <= tval_val;
        cur_priv <= PRIV_M;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        CFG_EDELEG: edeleg_q <= cfg_wdata;
        CFG_IDELEG: ideleg_q <= cfg_wdata;
        CFG_MVEC:   mvec_q   <= cfg_wdata;
        CFG_SVEC:   svec_q   <= cfg_wdata;
        CFG_STATUS: begin
          st_sie  <= cfg_wdata[0];
          st_mie  <= cfg_wdata[1];
          st_spie <= cfg_wdata[2];
          st_mpie <= cfg_wdata[3];
          st_spp  <= cfg_wdata[4];
          st_mpp  <= cfg_wdata[6:5];
        end
        CFG_PRIV:   cur_priv <= (cfg_wdata[1:0] == 2'd2) ? PRIV_U : cfg_wdata[1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               trap_valid,
  input logic               trap_irq,
  input logic [CAUSE_W-1:0] trap_code,
  input logic [XLEN-1:0]    pc_in,
  input logic               trap_to_s,
  input logic [XLEN-1:0]    trap_pc,
  input logic [1:0]         cur_priv,
  input logic               st_sie,
  input logic               st_mie,
  input logic               st_spie,
  input logic               st_mpie,
  input logic [1:0]         st_mpp,
  input logic [XLEN-1:0]    m_epc,
  input logic [XLEN-1:0]    s_cause
);
  AST_M_STAYS_M: assert property (@(posedge clk) disable iff (rst)
    trap_valid && cur_priv == 2'd3 |-> !trap_to_s); // R2
  AST_S_STACK: assert property (@(posedge clk) disable iff (rst)
    trap_valid && trap_to_s |=> !st_sie && st_spie == $past(st_sie)); // R3
  AST_M_STACK: assert property (@(posedge clk) disable iff (rst)
    trap_valid && !trap_to_s |=> !st_mie && st_mpie == $past(st_mie) && st_mpp == $past(cur_priv)); // R4
  AST_M_EPC: assert property (@(posedge clk) disable iff (rst)
    trap_valid && !trap_to_s |=> m_epc == $past(pc_in)); // R5
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    trap_valid && trap_irq && trap_to_s |=> s_cause[XLEN-1]); // R5
  AST_EXC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    trap_valid && !trap_irq |-> trap_pc[1:0] == 2'b00); // R6
  AST_PRIV_TARGET: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> cur_priv == ($past(trap_to_s) ? 2'd1 : 2'd3)); // R10
  AST_WIDE_CODE: assert property (@(posedge clk) disable iff (rst)
    trap_valid && int'(trap_code) >= XLEN |-> !trap_to_s); // R11
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_irq(trap_irq),
  .trap_code(trap_code), .pc_in(pc_in), .trap_to_s(trap_to_s), .trap_pc(trap_pc),
  .cur_priv(cur_priv), .st_sie(st_sie), .st_mie(st_mie), .st_spie(st_spie),
  .st_mpie(st_mpie), .st_mpp(st_mpp), .m_epc(m_epc), .s_cause(s_cause)
);

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_valid = 1'b0, trap_irq = 1'b0, cfg_we = 1'b0;
  logic [CW-1:0]   trap_code = '0;
  logic [XLEN-1:0] trap_addr = '0, pc_in = '0, cfg_wdata = '0;
  logic [2:0]      cfg_sel = '0;
  logic trap_taken, trap_to_s, st_sie, st_mie, st_spie, st_mpie, st_spp;
  logic [1:0] cur_priv, st_mpp;
  logic [XLEN-1:0] trap_pc, m_cause, m_epc, m_tval, s_cause, s_epc, s_tval;

  always #5 clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) dut (.*);

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // reference state
  logic [1:0]  r_priv;
  logic [31:0] r_ed, r_id, r_mv, r_sv, r_mc, r_me, r_mt, r_sc, r_se, r_st;
  logic r_sie, r_mie, r_spie, r_mpie, r_spp;
  logic [1:0] r_mpp;

  task automatic chk(string req, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual %h expected %h", req, tag, act, exp);
    end
  endtask

  function automatic int ref_code(logic irq, int code, logic [1:0] p);
    if (!irq && code == 8) return (p == 2'd0) ? 8 : (p == 2'd1) ? 9 : 11;
    return code;
  endfunction

  function automatic logic ref_to_s(logic irq, int code);
    if (r_priv == 2'd3 || code >= 32) return 1'b0;
    return irq ? r_id[code] : r_ed[code];
  endfunction

  task automatic model_reset();
    r_priv = 2'd3;
    {r_ed, r_id, r_mv, r_sv, r_mc, r_me, r_mt, r_sc, r_se, r_st} = '0;
    {r_sie, r_mie, r_spie, r_mpie, r_spp} = '0;
    r_mpp = 2'd0;
  endtask

  task automatic check_regs(string tag);
    chk("R10", tag, 32'(cur_priv), 32'(r_priv));
    chk("R3", tag, {27'd0, st_spp, st_spie, st_sie, 2'b00}, {27'd0, r_spp, r_spie, r_sie, 2'b00});
    chk("R4", tag, {27'd0, st_mpp, st_mpie, st_mie}, {27'd0, r_mpp, r_mpie, r_mie});
    chk("R5", tag, m_cause ^ m_epc, r_mc ^ r_me);
    chk("R5", tag, s_cause ^ {s_epc[15:0], s_epc[31:16]}, r_sc ^ {r_se[15:0], r_se[31:16]});
    chk("R5", tag, m_cause, r_mc);
    chk("R5", tag, s_cause, r_sc);
    chk("R8", tag, m_tval, r_mt);
    chk("R8", tag, s_tval, r_st);
  endtask

  // one clock: drive, check same-cycle outputs, advance model, check registers
  task automatic step(logic v, logic irq, int code, logic [31:0] addr, logic [31:0] pc,
                      logic we, logic [2:0] sel, logic [31:0] wd, string tag);
    int ec;
    logic tos;
    logic [31:0] vec, exp_pc, cause, tval;
    trap_valid = v; trap_irq = irq; trap_code = CW'(code); trap_addr = addr; pc_in = pc;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    #1;
    ec  = ref_code(irq, code, r_priv);
    tos = ref_to_s(irq, ec);
    vec = tos ? r_sv : r_mv;
    exp_pc = {vec[31:2], 2'b00};
    if (irq && vec[1:0] == 2'd1) exp_pc = exp_pc + 32'(ec) * 4;
    chk("R10", tag, 32'(trap_taken), 32'(v));
    if (v) begin
      chk("R1", tag, 32'(trap_to_s), 32'(tos));
      chk(irq ? "R7" : "R6", tag, trap_pc, exp_pc);
    end
    @(posedge clk);
    cause = {irq, 25'd0, 6'(ec)};
    tval = (!irq && (ec inside {0, 1, 4, 5, 6, 7, 12, 13, 15})) ? addr : 32'd0;
    if (v) begin
      if (tos) begin
        r_spie = r_sie; r_spp = (r_priv == 2'd1); r_sie = 1'b0;
        r_sc = cause; r_se = pc; r_st = tval; r_priv = 2'd1;
      end else begin
        r_mpie = r_mie; r_mpp = r_priv; r_mie = 1'b0;
        r_mc = cause; r_me = pc; r_mt = tval; r_priv = 2'd3;
      end
    end else if (we) begin
      case (sel)
        3'd0: r_ed = wd;
        3'd1: r_id = wd;
        3'd2: r_mv = wd;
        3'd3: r_sv = wd;
        3'd4: begin
          r_sie = wd[0]; r_mie = wd[1]; r_spie = wd[2]; r_mpie = wd[3];
          r_spp = wd[4]; r_mpp = wd[6:5];
        end
        3'd5: r_priv = (wd[1:0] == 2'd2) ? 2'd0 : wd[1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    check_regs(tag);
  endtask

  task automatic cfg(logic [2:0] sel, logic [31:0] wd, string tag);
    step(0, 0, 0, 0, 0, 1, sel, wd, tag);
  endtask

  task automatic trap(logic irq, int code, logic [31:0] addr, logic [31:0] pc, string tag);
    step(1, irq, code, addr, pc, 0, 3'd0, 0, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_regs("R12 reset state");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R12 idle");
    // R13 config loads
    cfg(3'd2, 32'h0000_1000, "R13 mvec");
    cfg(3'd3, 32'h0000_2001, "R13 svec vectored");
    cfg(3'd4, 32'h0000_0003, "R13 status");
    // R2 M with all delegation set stays in M
    cfg(3'd0, 32'hFFFF_FFFF, "R13 edeleg");
    trap(0, 5, 32'hDEAD_0005, 32'h100, "R2 from M");
    // R1 page fault from U delegates
    cfg(3'd0, 32'h0000_2000, "R13 edeleg bit13");
    cfg(3'd5, 32'd0, "R13 priv U");
    cfg(3'd4, 32'h0000_0003, "R13 status again");
    trap(0, 13, 32'hCAFE_0013, 32'h200, "R1 R3 R8 pf from U");
    // R9 ecall from S with only bit 8 set goes to M as 11? from S it is 9
    cfg(3'd0, 32'h0000_0100, "R13 edeleg bit8");
    cfg(3'd5, 32'd1, "R13 priv S");
    trap(0, 8, 32'h1111, 32'h300, "R9 ecall from S");
    cfg(3'd5, 32'd0, "R13 priv U");
    trap(0, 8, 32'h2222, 32'h304, "R9 ecall from U");
    trap(0, 8, 32'h3333, 32'h308, "R9 ecall from S after U");
    cfg(3'd5, 32'd3, "R13 priv M");
    trap(0, 8, 32'h4444, 32'h30C, "R9 ecall from M");
    // R7 vectored interrupt to S; R1 separate masks
    cfg(3'd1, 32'h0000_0020, "R13 ideleg bit5");
    cfg(3'd0, 32'h0000_0200, "R13 edeleg bit9");
    cfg(3'd5, 32'd2, "R13 priv reserved maps to U");
    trap(1, 5, 32'h5555, 32'h400, "R7 R8 vectored irq to S");
    trap(1, 9, 32'h6666, 32'h404, "R1 irq uses interrupt mask");
    cfg(3'd5, 32'd1, "R13 priv S");
    trap(0, 5, 32'h7777, 32'h408, "R1 exc uses exception mask");
    // R6 vectored mode ignored for exceptions; mode 3 not vectored
    cfg(3'd0, 32'h0000_0020, "R13 edeleg bit5");
    cfg(3'd5, 32'd0, "R13 priv U");
    trap(0, 5, 32'h8888, 32'h40C, "R6 exception direct on vectored base");
    cfg(3'd2, 32'h0000_3003, "R13 mvec mode3");
    cfg(3'd5, 32'd3, "R13 priv M");
    trap(1, 7, 32'h9999, 32'h410, "R6 mode3 irq direct");
    cfg(3'd2, 32'h0000_3001, "R13 mvec mode1");
    trap(1, 11, 32'hAAAA, 32'h414, "R7 vectored irq to M");
    // R8 breakpoint carries no address
    trap(0, 3, 32'hBBBB, 32'h418, "R8 breakpoint zero tval");
    trap(0, 0, 32'hCCCC, 32'h41C, "R8 misaligned fetch");
    // R11 wide code never delegates
    cfg(3'd0, 32'hFFFF_FFFF, "R13 edeleg all");
    cfg(3'd1, 32'hFFFF_FFFF, "R13 ideleg all");
    cfg(3'd5, 32'd0, "R13 priv U");
    trap(1, 40, 32'hDDDD, 32'h500, "R11 code 40 irq");
    cfg(3'd5, 32'd0, "R13 priv U");
    trap(0, 63, 32'hEEEE, 32'h504, "R11 code 63 exc");
    // R13 write alongside trap is dropped
    cfg(3'd5, 32'd1, "R13 priv S");
    step(1, 0, 12, 32'hF00D, 32'h600, 1, 3'd5, 32'd0, "R13 trap wins over priv write");
    step(1, 0, 4, 32'hBEEF, 32'h604, 1, 3'd4, 32'h7F, "R13 trap wins over status write");
    trap(0, 2, 32'h1234, 32'h608, "R4 second M entry");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R10 actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule